// File: doc/BRIEF.md
# Host Memory Slave Port

This block lets an external host reach on-chip program and data memories over one 16-bit bus that carries both addresses and data. The host first loads a pointer with an address-latch access. The 15-bit value on the bus then selects a 14-bit word address and a memory space. After that, plain read and write accesses go through the pointer and advance it, so a long block of code or data moves with no further address cycles.

Data memory holds 16-bit words, and each access moves one whole word. Program memory holds 24-bit words, and each word takes two accesses. The first access carries the upper sixteen bits. The second carries the low byte in bits 7:0, with bits 15:8 at zero. The pointer advances only once both halves have moved.

When the block starts in boot mode, it keeps the local core halted until the host completes a program-memory write to address 0. That word is the restart vector, so a host loads everything else first and writes this word last.

All bus inputs are sampled on the rising clock edge. Each clock cycle in which the select and one strobe are both high counts as one access. The acknowledge and any read data appear in the following cycle.

Top module: `hostmem_port`

## Requirements
- R1: An access with `sel_i` and `ale_i` high loads the pointer from `bus_i[13:0]` and the space flag from `bus_i[14]` (1 = program memory, 0 = data memory). It also returns the half-word phase to "upper half".
- R2: A data-space write stores `bus_i` at the pointer's word and then advances the pointer by one.
- R3: A data-space read places the addressed word on `bus_o`, with `bus_oe_o` high, in the cycle after the access, and advances the pointer by one.
- R4: A program-space write in the upper phase keeps `bus_i` as the upper 16 bits and does not move the pointer. The following write stores {upper, `bus_i[7:0]`} as one 24-bit word and then advances the pointer.
- R5: A program-space read returns bits 23:8 of the word on the first access. The second access returns {8'h00, bits 7:0}, and the pointer advances only after that second access.
- R6: An address-latch access between the two halves of a program word throws away the pending upper half. The next program access is treated as an upper half.
- R7: When `ale_i` is high together with `wr_i` or `rd_i`, only the latch takes place. No memory is written, and `bus_oe_o` stays low.
- R8: The pointer counts modulo 2^14, so the word after 0x3FFF is 0x0000. Each memory is indexed by the pointer modulo its depth.
- R9: `ack_o` is high for exactly the one cycle after each access. It is low otherwise, and strobes with `sel_i` low are ignored entirely.
- R10: With `boot_mode_i` high, `core_run_o` stays low after reset until the second half of a program write to address 0 completes. It then stays high. A data write to address 0, or an upper half alone, does not release the core.
- R11: With `boot_mode_i` low, `core_run_o` goes high in the first cycle after reset ends.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| boot_mode_i | input | 1 | High: hold the core until the restart vector is written |
| sel_i | input | 1 | Port select |
| ale_i | input | 1 | Address-latch strobe |
| rd_i | input | 1 | Read strobe |
| wr_i | input | 1 | Write strobe |
| bus_i | input | 16 | Address or data from the host |
| bus_o | output | 16 | Read data to the host |
| bus_oe_o | output | 1 | Read data valid, drive the bus |
| ack_o | output | 1 | Access acknowledge |
| core_run_o | output | 1 | Core released to run |

## Verification
The bench builds the block with 64-word program and data memories instead of the default 256. At that depth, the wrap of the pointer from 0x3FFF to 0x0000 can be checked against distinct memory words: 0x3FFF lands on word 63 and its successor on word 0. The small depth also lets the same bench cover the restart-vector write at program address 0, the two-half program packing, and the latch priority without long fill sequences.

// File: rtl/hostmem_pkg.sv
package hostmem_pkg;
    localparam int HBUS_W = 16;
    localparam int ADDR_W = 14;
    localparam int PM_W   = 24;
    localparam int LO_W   = PM_W - HBUS_W;

    typedef enum logic [1:0] {
        RK_DM    = 2'd0,
        RK_PM_HI = 2'd1,
        RK_PM_LO = 2'd2
    } rd_kind_e;

    typedef struct packed {
        logic [ADDR_W-1:0] addr;
        logic              pm;
        logic              lo_phase;
        logic [HBUS_W-1:0] hold;
    } ptr_state_t;

    typedef struct packed {
        logic     ack;
        logic     oe;
        rd_kind_e kind;
    } resp_state_t;
endpackage

// File: rtl/hostmem_ram.sv
module hostmem_ram #(
    parameter int W     = 16,
    parameter int DEPTH = 256,
    parameter int AW    = 14
) (
    input  logic          clk,
    input  logic          we,
    input  logic [AW-1:0] waddr,
    input  logic [W-1:0]  wdata,
    input  logic          re,
    input  logic [AW-1:0] raddr,
    output logic [W-1:0]  rdata
);
    localparam int IW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam logic [AW-1:0] DEPTH_L = AW'(DEPTH);

    logic [W-1:0]  mem [DEPTH];
    logic [W-1:0]  rdata_d, rdata_q;
    logic [IW-1:0] widx, ridx;

    always_comb begin
        widx    = IW'(waddr % DEPTH_L);
        ridx    = IW'(raddr % DEPTH_L);
        rdata_d = rdata_q;
        if (re) begin
            rdata_d = mem[ridx];
        end
    end

    always_ff @(posedge clk) begin
        if (we) begin
            mem[widx] <= wdata;
        end
        rdata_q <= rdata_d;
    end

    assign rdata = rdata_q;
endmodule

// File: rtl/hostmem_ptr.sv
module hostmem_ptr
    import hostmem_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              do_latch,
    input  logic              do_wr,
    input  logic              do_rd,
    input  logic [HBUS_W-1:0] bus_i,
    output logic [ADDR_W-1:0] addr_o,
    output logic              pm_space_o,
    output logic              lo_phase_o,
    output logic              pm_we_o,
    output logic [PM_W-1:0]   pm_wdata_o,
    output logic              dm_we_o,
    output logic              pm_re_o,
    output logic              dm_re_o,
    output rd_kind_e          kind_o
);
    ptr_state_t s_d, s_q;

    always_comb begin
        s_d        = s_q;
        pm_we_o    = 1'b0;
        dm_we_o    = 1'b0;
        pm_re_o    = 1'b0;
        dm_re_o    = 1'b0;
        kind_o     = RK_DM;
        pm_wdata_o = {s_q.hold, bus_i[LO_W-1:0]};
        if (do_latch) begin
            s_d.addr     = bus_i[ADDR_W-1:0];
            s_d.pm       = bus_i[ADDR_W];
            s_d.lo_phase = 1'b0;
        end else if (do_wr) begin
            if (s_q.pm) begin
                if (!s_q.lo_phase) begin
                    s_d.hold     = bus_i;
                    s_d.lo_phase = 1'b1;
                end else begin
                    pm_we_o      = 1'b1;
                    s_d.lo_phase = 1'b0;
                    s_d.addr     = s_q.addr + 1'b1;
                end
            end else begin
                dm_we_o  = 1'b1;
                s_d.addr = s_q.addr + 1'b1;
            end
        end else if (do_rd) begin
            if (s_q.pm) begin
                pm_re_o      = 1'b1;
                kind_o       = s_q.lo_phase ? RK_PM_LO : RK_PM_HI;
                s_d.lo_phase = !s_q.lo_phase;
                if (s_q.lo_phase) begin
                    s_d.addr = s_q.addr + 1'b1;
                end
            end else begin
                dm_re_o  = 1'b1;
                s_d.addr = s_q.addr + 1'b1;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            s_q <= '0;
        end else begin
            s_q <= s_d;
        end
    end

    assign addr_o     = s_q.addr;
    assign pm_space_o = s_q.pm;
    assign lo_phase_o = s_q.lo_phase;
endmodule

// File: rtl/hostmem_boot.sv
module hostmem_boot
    import hostmem_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              boot_mode_i,
    input  logic              pm_we_i,
    input  logic [ADDR_W-1:0] pm_waddr_i,
    output logic              run_o
);
    logic run_d, run_q;

    always_comb begin
        run_d = run_q;
        if (!boot_mode_i) begin
            run_d = 1'b1;
        end else if (pm_we_i && (pm_waddr_i == '0)) begin
            run_d = 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            run_q <= 1'b0;
        end else begin
            run_q <= run_d;
        end
    end

    assign run_o = run_q;
endmodule

// File: rtl/hostmem_port.sv
module hostmem_port
    import hostmem_pkg::*;
#(
    parameter int PM_DEPTH = 256,
    parameter int DM_DEPTH = 256
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              boot_mode_i,
    input  logic              sel_i,
    input  logic              ale_i,
    input  logic              rd_i,
    input  logic              wr_i,
    input  logic [HBUS_W-1:0] bus_i,
    output logic [HBUS_W-1:0] bus_o,
    output logic              bus_oe_o,
    output logic              ack_o,
    output logic              core_run_o
);
    logic              do_latch, do_wr, do_rd, any_acc;
    logic [ADDR_W-1:0] ptr_addr;
    logic              pm_space, lo_phase;
    logic              pm_we, dm_we, pm_re, dm_re;
    logic [PM_W-1:0]   pm_wdata, pm_rdata;
    logic [HBUS_W-1:0] dm_rdata;
    rd_kind_e          kind;
    resp_state_t       r_d, r_q;

    // Latch wins over both data strobes; write wins over read.
    always_comb begin
        do_latch = sel_i && ale_i;
        do_wr    = sel_i && wr_i && !ale_i;
        do_rd    = sel_i && rd_i && !ale_i && !wr_i;
        any_acc  = do_latch || do_wr || do_rd;
    end

    hostmem_ptr ptr_i (
        .clk        (clk),
        .rst_n      (rst_n),
        .do_latch   (do_latch),
        .do_wr      (do_wr),
        .do_rd      (do_rd),
        .bus_i      (bus_i),
        .addr_o     (ptr_addr),
        .pm_space_o (pm_space),
        .lo_phase_o (lo_phase),
        .pm_we_o    (pm_we),
        .pm_wdata_o (pm_wdata),
        .dm_we_o    (dm_we),
        .pm_re_o    (pm_re),
        .dm_re_o    (dm_re),
        .kind_o     (kind)
    );

    hostmem_ram #(.W(PM_W), .DEPTH(PM_DEPTH), .AW(ADDR_W)) pm_ram_i (
        .clk   (clk),
        .we    (pm_we),
        .waddr (ptr_addr),
        .wdata (pm_wdata),
        .re    (pm_re),
        .raddr (ptr_addr),
        .rdata (pm_rdata)
    );

    hostmem_ram #(.W(HBUS_W), .DEPTH(DM_DEPTH), .AW(ADDR_W)) dm_ram_i (
        .clk   (clk),
        .we    (dm_we),
        .waddr (ptr_addr),
        .wdata (bus_i),
        .re    (dm_re),
        .raddr (ptr_addr),
        .rdata (dm_rdata)
    );

    hostmem_boot boot_i (
        .clk         (clk),
        .rst_n       (rst_n),
        .boot_mode_i (boot_mode_i),
        .pm_we_i     (pm_we),
        .pm_waddr_i  (ptr_addr),
        .run_o       (core_run_o)
    );

    always_comb begin
        r_d     = r_q;
        r_d.ack = any_acc;
        r_d.oe  = do_rd;
        if (do_rd) begin
            r_d.kind = kind;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            r_q <= '{ack: 1'b0, oe: 1'b0, kind: RK_DM};
        end else begin
            r_q <= r_d;
        end
    end

    always_comb begin
        unique case (r_q.kind)
            RK_PM_HI: bus_o = pm_rdata[PM_W-1:LO_W];
            RK_PM_LO: bus_o = {{(HBUS_W-LO_W){1'b0}}, pm_rdata[LO_W-1:0]};
            default:  bus_o = dm_rdata;
        endcase
    end

    assign ack_o    = r_q.ack;
    assign bus_oe_o = r_q.oe;
endmodule

// File: rtl/hostmem_port_chk.sv
module hostmem_port_chk
    import hostmem_pkg::*;
(
    input logic              clk,
    input logic              rst_n,
    input logic              boot_mode_i,
    input logic              sel_i,
    input logic              ale_i,
    input logic              rd_i,
    input logic              wr_i,
    input logic [ADDR_W:0]   lat_val,
    input logic              bus_oe_o,
    input logic              ack_o,
    input logic              core_run_o,
    input logic [ADDR_W-1:0] ptr_addr,
    input logic              pm_space,
    input logic              lo_phase,
    input logic              pm_we,
    input logic              dm_we
);
    AST_LATCH_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
        sel_i && ale_i |=> !lo_phase && ptr_addr == $past(lat_val[ADDR_W-1:0]) && pm_space == $past(lat_val[ADDR_W])); // R1
    AST_DM_ADVANCE: assert property (@(posedge clk) disable iff (!rst_n)
        sel_i && wr_i && !ale_i && !pm_space |=> ptr_addr == ADDR_W'($past(ptr_addr) + 1'b1)); // R2
    AST_OE_WITH_ACK: assert property (@(posedge clk) disable iff (!rst_n)
        bus_oe_o |-> ack_o); // R3
    AST_PM_UPPER_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        sel_i && wr_i && !ale_i && pm_space && !lo_phase |=> $stable(ptr_addr) && lo_phase); // R4
    AST_LATCH_NO_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
        sel_i && ale_i |-> !pm_we && !dm_we); // R7
    AST_ACK_FOLLOWS: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n) |-> ack_o == $past(sel_i && (ale_i || rd_i || wr_i))); // R9
    AST_RUN_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        core_run_o |=> core_run_o); // R10
    AST_RUN_ON_VECTOR: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n) && boot_mode_i && $past(boot_mode_i) && $rose(core_run_o) |-> $past(pm_we && ptr_addr == '0)); // R10
endmodule

bind hostmem_port hostmem_port_chk chk_i (
    .clk         (clk),
    .rst_n       (rst_n),
    .boot_mode_i (boot_mode_i),
    .sel_i       (sel_i),
    .ale_i       (ale_i),
    .rd_i        (rd_i),
    .wr_i        (wr_i),
    .lat_val     (bus_i[14:0]),
    .bus_oe_o    (bus_oe_o),
    .ack_o       (ack_o),
    .core_run_o  (core_run_o),
    .ptr_addr    (ptr_addr),
    .pm_space    (pm_space),
    .lo_phase    (lo_phase),
    .pm_we       (pm_we),
    .dm_we       (dm_we)
);

// File: tb/hostmem_port_tb_top.sv
module hostmem_port_tb_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        boot_mode_i = 1'b1;
    logic        sel_i = 1'b0, ale_i = 1'b0, rd_i = 1'b0, wr_i = 1'b0;
    logic [15:0] bus_i = '0;
    logic [15:0] bus_o;
    logic        bus_oe_o, ack_o, core_run_o;
    int          n_chk = 0, n_fail = 0;
    bit          done = 1'b0;

    always #5 clk = ~clk;

    hostmem_port #(.PM_DEPTH(64), .DM_DEPTH(64)) dut_i (
        .clk(clk), .rst_n(rst_n), .boot_mode_i(boot_mode_i),
        .sel_i(sel_i), .ale_i(ale_i), .rd_i(rd_i), .wr_i(wr_i),
        .bus_i(bus_i), .bus_o(bus_o), .bus_oe_o(bus_oe_o),
        .ack_o(ack_o), .core_run_o(core_run_o)
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    // One access cycle; results are visible at the following falling edge.
    task automatic acc(input logic s, input logic a, input logic r, input logic w, input logic [15:0] d);
        @(negedge clk);
        sel_i = s; ale_i = a; rd_i = r; wr_i = w; bus_i = d;
        @(negedge clk);
        sel_i = 0; ale_i = 0; rd_i = 0; wr_i = 0; bus_i = '0;
    endtask

    task automatic do_latch(input logic pm, input logic [13:0] a);
        acc(1, 1, 0, 0, {1'b0, pm, a});
        chk("R1 latch ack", ack_o, 1);
        chk("R7 latch no oe", bus_oe_o, 0);
    endtask

    task automatic do_write(input logic [15:0] d);
        acc(1, 0, 0, 1, d);
        chk("R9 write ack", ack_o, 1);
    endtask

    task automatic do_read(input logic [15:0] exp, input string tag);
        acc(1, 0, 1, 0, '0);
        chk({tag, " ack"}, ack_o, 1);
        chk({tag, " oe"}, bus_oe_o, 1);
        chk({tag, " data"}, bus_o, exp);
    endtask

    task automatic do_reset(input logic boot);
        boot_mode_i = boot;
        rst_n = 0;
        repeat (3) @(negedge clk);
        rst_n = 1;
    endtask

    task automatic t_reset;
        do_reset(1);
        @(negedge clk);
        chk("R9 reset ack", ack_o, 0);
        chk("R3 reset oe", bus_oe_o, 0);
        chk("R10 reset run", core_run_o, 0);
    endtask

    task automatic t_dm;
        do_latch(0, 14'h0010);
        do_write(16'h1111); do_write(16'h2222); do_write(16'h3333);
        do_latch(0, 14'h0010);
        do_read(16'h1111, "R2 R3 dm0");
        do_read(16'h2222, "R2 R3 dm1");
        do_read(16'h3333, "R2 R3 dm2");
    endtask

    task automatic t_pm;
        do_latch(1, 14'h0005);
        do_write(16'hABCD); do_write(16'h0012);
        do_write(16'h5566); do_write(16'h0077);
        do_latch(1, 14'h0005);
        do_read(16'hABCD, "R4 R5 pm5 hi");
        do_read(16'h0012, "R4 R5 pm5 lo");
        do_read(16'h5566, "R4 R5 pm6 hi");
        do_read(16'h0077, "R4 R5 pm6 lo");
        chk("R10 no run before vector", core_run_o, 0);
    endtask

    task automatic t_phase;
        do_latch(1, 14'h0008);
        do_write(16'hDEAD);
        do_latch(1, 14'h0008);
        do_write(16'h1234); do_write(16'h0056);
        do_latch(1, 14'h0008);
        do_read(16'h1234, "R6 pm8 hi");
        do_read(16'h0056, "R6 pm8 lo");
        do_latch(1, 14'h0005);
        do_read(16'hABCD, "R6 read pm5 hi");
        do_latch(1, 14'h0005);
        do_read(16'hABCD, "R6 relatch pm5 hi");
    endtask

    task automatic t_prio;
        do_latch(0, 14'd10);
        do_write(16'h000A); do_write(16'h000B); do_write(16'h000C); do_write(16'h000D);
        acc(1, 1, 0, 1, {2'b00, 14'd11});
        chk("R7 ale+wr ack", ack_o, 1);
        do_read(16'h000B, "R7 dm11");
        do_read(16'h000C, "R7 dm12");
        do_read(16'h000D, "R7 dm13");
        acc(1, 1, 1, 0, {2'b00, 14'd10});
        chk("R7 ale+rd no oe", bus_oe_o, 0);
        do_read(16'h000A, "R7 ale+rd latched dm10");
    endtask

    task automatic t_wrap;
        do_latch(0, 14'h3FFF);
        do_write(16'hF00F); do_write(16'h0FF0);
        do_latch(0, 14'h0000);
        do_read(16'h0FF0, "R8 wrap dm0");
        do_latch(0, 14'd63);
        do_read(16'hF00F, "R8 dm63");
    endtask

    task automatic t_ignore;
        do_latch(0, 14'd20);
        do_write(16'h4444); do_write(16'h5555);
        do_latch(0, 14'd21);
        acc(0, 0, 0, 1, 16'h9999);
        chk("R9 unselected no ack", ack_o, 0);
        @(negedge clk);
        chk("R9 idle ack low", ack_o, 0);
        do_latch(0, 14'd20);
        do_read(16'h4444, "R9 dm20");
        do_read(16'h5555, "R9 dm21 untouched");
    endtask

    task automatic t_boot;
        do_latch(0, 14'h0000);
        do_write(16'h0001);
        chk("R10 dm0 keeps halt", core_run_o, 0);
        do_latch(1, 14'h0000);
        do_write(16'h00AA);
        chk("R10 upper half keeps halt", core_run_o, 0);
        do_write(16'h00BB);
        chk("R10 vector releases", core_run_o, 1);
        do_latch(0, 14'd30);
        do_write(16'h1234);
        chk("R10 run stays", core_run_o, 1);
        do_latch(1, 14'h0000);
        do_read(16'h00AA, "R10 vector hi");
        do_read(16'h00BB, "R10 vector lo");
    endtask

    task automatic t_noboot;
        do_reset(0);
        @(negedge clk);
        chk("R11 run without boot", core_run_o, 1);
    endtask

    initial begin
        t_reset();
        t_dm();
        t_pm();
        t_phase();
        t_prio();
        t_wrap();
        t_ignore();
        t_boot();
        t_noboot();
        if (!done) begin
            done = 1'b1;
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            n_chk++;
            n_fail++;
            $display("FAIL watchdog actual=timeout expected=finish");
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end
endmodule